// File: doc/BRIEF.md
# Handshake FIFO Read-Side Strobe Controller

This block sits on the read side of one or more FIFOs that have a flag-and-strobe interface and that are placed side by side to form a wider word. It merges the per-lane output-ready flags into one composite flag and the per-lane input-ready flags into one composite flag for the write side. It issues a shift-out strobe to all lanes together, and it latches the combined output word on the cycle the strobe rises. The captured word goes to a downstream consumer over a valid/ready pair.

Each strobe is a handshake. It rises only when the composite output-ready is high, and it stays high until the lanes acknowledge it by dropping that flag. Parameterised minimum high and low widths mean that no short pulse reaches the FIFOs at the full or empty boundary. A two-bit mode input selects one of three start policies. In plain handshake mode a strobe starts as soon as data is reported. In guard mode the first strobe after the FIFOs leave empty is held back for a fixed number of cycles. In half-full mode reading begins only once the occupancy exceeds half the depth, and it then continues until the FIFOs are empty. The controller counts occupancy itself from a write pulse input and its own strobes. All delays are counted in clock cycles.

Top module: `fifo_rdctl`

## Requirements
- R1: `comp_or` is high only when every bit of `lane_or` is high, and `all_ir` is high only when every bit of `lane_ir` is high. With any lane's output-ready low, no strobe is issued.
- R2: `shift_out` rises only in the cycle after one in which `comp_or` was high. Once high, it stays high for as long as `comp_or` remains high, and it falls only after `comp_or` has gone low.
- R3: On the clock edge where `shift_out` rises, `lane_do` is registered into `out_data` and `out_valid` is set. Lane i occupies bits [i*WIDTH +: WIDTH]. Words reach the consumer in the order they were written.
- R4: In guard mode (`mode_sel` = 1), the first strobe after the occupancy leaves zero rises no earlier than GUARD_CYC+1 cycles after `comp_or` first rises. The guard is re-armed each time the occupancy returns to zero.
- R5: In half-full mode (`mode_sel` = 2), occupancy is counted up by `wr_pulse` and down by each strobe. No strobe starts until the occupancy exceeds DEPTH/2. Once started, strobes continue until the occupancy is zero.
- R6: Every `shift_out` high phase lasts at least MIN_HI cycles. Every low phase between two strobes lasts at least MIN_LO cycles.
- R7: While `out_valid` is high and `out_ready` is low, no new strobe starts.
- R8: While `rst_n` is low, `shift_out` and `out_valid` are low, the occupancy count is zero and the guard is armed.
- R9: In handshake mode (`mode_sel` = 0, and also 3), a strobe rises on the first clock edge at which `comp_or` is high and the low-phase minimum has been met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 handshake, 1 guard delay, 2 half-full start, 3 handshake |
| wr_pulse | input | 1 | One-cycle pulse for each word written into the FIFOs |
| lane_or | input | LANES | Output-ready flag from each FIFO lane |
| lane_ir | input | LANES | Input-ready flag from each FIFO lane |
| lane_do | input | LANES*WIDTH | Output data from each lane, lane i at [i*WIDTH +: WIDTH] |
| shift_out | output | 1 | Shift-out strobe to all lanes |
| all_ir | output | 1 | Composite input-ready for the write side |
| comp_or | output | 1 | Composite output-ready |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | LANES*WIDTH | Captured word |

## Verification
The bench builds the block with two four-bit lanes, a depth of 8, GUARD_CYC of 3 and MIN_HI and MIN_LO of 2. The lanes are driven by a behavioural FIFO model that clears its output-ready while the strobe is high and pops on its fall. With a depth of 8, the half-full start needs only five writes, and filling a lane completely drives the composite input-ready low. A guard of three cycles makes the delayed first strobe clearly distinct from the single-cycle start in handshake mode. Override masks on individual lane flags show that the merged flags follow the weakest lane.

// File: rtl/fifo_rdctl_pkg.sv
package fifo_rdctl_pkg;

  typedef enum logic [1:0] {
    RD_MODE_HANDSHAKE = 2'd0,
    RD_MODE_GUARD     = 2'd1,
    RD_MODE_HALF      = 2'd2,
    RD_MODE_SPARE     = 2'd3
  } rd_mode_e;

  // bits needed to hold values 0..maxv, never less than one
  function automatic int unsigned cnt_w(input int unsigned maxv);
    return (maxv < 1) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/rdctl_flag_merge.sv
module rdctl_flag_merge #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_or,
  input  logic [LANES-1:0] lane_ir,
  output logic             comp_or,
  output logic             comp_ir
);

  logic [LANES:0] or_chain;
  logic [LANES:0] ir_chain;

  assign or_chain[0] = 1'b1;
  assign ir_chain[0] = 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign or_chain[g+1] = or_chain[g] & lane_or[g];
    assign ir_chain[g+1] = ir_chain[g] & lane_ir[g];
  end

  assign comp_or = or_chain[LANES];
  assign comp_ir = ir_chain[LANES];

endmodule

// File: rtl/rdctl_occupancy.sv
module rdctl_occupancy #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pulse,
  input  logic rd_launch,
  output logic occ_zero,
  output logic draining
);

  localparam int OCC_W = fifo_rdctl_pkg::cnt_w(DEPTH);
  localparam logic [OCC_W-1:0] HALF_C  = OCC_W'(DEPTH / 2);
  localparam logic [OCC_W-1:0] DEPTH_C = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ_q, occ_n;
  logic             drain_q, drain_n;

  always_comb begin
    occ_n = occ_q;
    unique case ({wr_pulse, rd_launch})
      2'b10:   occ_n = occ_q + 1'b1;
      2'b01:   occ_n = occ_q - 1'b1;
      default: occ_n = occ_q;
    endcase
  end

  always_comb begin
    drain_n = drain_q;
    if (occ_q > HALF_C)
      drain_n = 1'b1;
    else if (occ_q == '0)
      drain_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      occ_q   <= occ_n;
      drain_q <= drain_n;
    end
  end

  assign occ_zero = (occ_q == '0);
  assign draining = drain_q;

  // R5: the count never goes below zero and never passes the depth
  assert_occ_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |-> !rd_launch);
  assert_occ_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == DEPTH_C) |-> !(wr_pulse && !rd_launch));

endmodule

// File: rtl/rdctl_start_gate.sv
module rdctl_start_gate
  import fifo_rdctl_pkg::*;
#(
  parameter int GUARD_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rd_mode_e mode,
  input  logic     comp_or,
  input  logic     launch,
  input  logic     occ_zero,
  input  logic     draining,
  output logic     gate_ok
);

  localparam int GW = cnt_w(GUARD_CYC);
  localparam logic [GW-1:0] GUARD_C = GW'(GUARD_CYC);

  logic          armed_q, armed_n;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic          guard_ok;

  always_comb begin
    armed_n = armed_q;
    if (launch)
      armed_n = 1'b0;
    else if (occ_zero)
      armed_n = 1'b1;
  end

  always_comb begin
    gcnt_n = gcnt_q;
    if (!armed_q || !comp_or)
      gcnt_n = '0;
    else if (gcnt_q < GUARD_C)
      gcnt_n = gcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      gcnt_q  <= '0;
    end else begin
      armed_q <= armed_n;
      gcnt_q  <= gcnt_n;
    end
  end

  assign guard_ok = !armed_q || (gcnt_q >= GUARD_C);

  always_comb begin
    unique case (mode)
      RD_MODE_GUARD: gate_ok = guard_ok;
      RD_MODE_HALF:  gate_ok = draining;
      default:       gate_ok = 1'b1;
    endcase
  end

  if (GUARD_CYC > 0) begin : g_guard_chk
    // R4: an armed guard that saw the flag low blocks the next cycle's strobe
    assert_guard_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RD_MODE_GUARD && armed_q && !comp_or) |=> !launch);
  end

endmodule

// File: rtl/rdctl_strobe_fsm.sv
module rdctl_strobe_fsm #(
  parameter int MIN_HI = 2,
  parameter int MIN_LO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comp_or,
  input  logic gate_ok,
  input  logic out_free,
  output logic shift_out,
  output logic launch
);

  localparam int CMAX = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
  localparam int CW   = fifo_rdctl_pkg::cnt_w(CMAX);
  localparam logic [CW-1:0] MIN_HI_C = CW'(MIN_HI);
  localparam logic [CW-1:0] MIN_LO_C = CW'(MIN_LO);

  logic          so_q, so_n;
  logic [CW-1:0] hi_q, hi_n;
  logic [CW-1:0] lo_q, lo_n;
  logic          hi_ok, lo_ok, drop;

  assign hi_ok  = (hi_q >= MIN_HI_C);
  assign lo_ok  = (lo_q >= MIN_LO_C);
  assign launch = !so_q && comp_or && gate_ok && out_free && lo_ok;
  assign drop   = so_q && !comp_or && hi_ok;

  always_comb begin
    so_n = so_q;
    hi_n = hi_q;
    lo_n = lo_q;
    if (launch) begin
      so_n = 1'b1;
      hi_n = CW'(1);
    end else if (drop) begin
      so_n = 1'b0;
      lo_n = CW'(1);
    end else if (so_q && !hi_ok) begin
      hi_n = hi_q + 1'b1;
    end else if (!so_q && !lo_ok) begin
      lo_n = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
      hi_q <= '0;
      lo_q <= MIN_LO_C;
    end else begin
      so_q <= so_n;
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  assign shift_out = so_q;

  // R2: a strobe starts only after a cycle with the composite flag high
  assert_rise_needs_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_q) |-> $past(comp_or));
  // R2: the strobe is not released while the lanes still report ready
  assert_hold_until_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (so_q && comp_or) |=> so_q);

  if (MIN_HI >= 2) begin : g_hi_chk
    // R6: a freshly raised strobe is still high one cycle later
    assert_min_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_q) |=> so_q);
  end
  if (MIN_LO >= 2) begin : g_lo_chk
    // R6: a freshly released strobe is still low one cycle later
    assert_min_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(so_q) |=> !so_q);
  end

endmodule

// File: rtl/rdctl_capture.sv
module rdctl_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [DW-1:0] lane_do,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_free
);

  logic          vld_q, vld_n;
  logic [DW-1:0] dat_q;
  logic          dat_en;

  assign dat_en = launch;

  always_comb begin
    vld_n = vld_q;
    if (launch)
      vld_n = 1'b1;
    else if (vld_q && out_ready)
      vld_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_n;
      if (dat_en)
        dat_q <= lane_do;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_free  = !vld_q || out_ready;

  // R3: the word on the lanes at the strobe's leading edge is what is presented
  assert_capture_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (vld_q && dat_q == $past(lane_do)));
  // R7: a stalled word blocks any new strobe
  assert_no_launch_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |-> !launch);

endmodule

// File: rtl/fifo_rdctl.sv
module fifo_rdctl
  import fifo_rdctl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int WIDTH     = 4,
  parameter int DEPTH     = 64,
  parameter int GUARD_CYC = 2,
  parameter int MIN_HI    = 2,
  parameter int MIN_LO    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_sel,
  input  logic                   wr_pulse,
  input  logic [LANES-1:0]       lane_or,
  input  logic [LANES-1:0]       lane_ir,
  input  logic [LANES*WIDTH-1:0] lane_do,
  output logic                   shift_out,
  output logic                   all_ir,
  output logic                   comp_or,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*WIDTH-1:0] out_data
);

  localparam int DW = LANES * WIDTH;

  rd_mode_e mode;
  logic     launch;
  logic     gate_ok;
  logic     out_free;
  logic     occ_zero;
  logic     draining;

  assign mode = rd_mode_e'(mode_sel);

  rdctl_flag_merge #(.LANES(LANES)) u_merge (
    .lane_or (lane_or),
    .lane_ir (lane_ir),
    .comp_or (comp_or),
    .comp_ir (all_ir)
  );

  rdctl_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .rd_launch (launch),
    .occ_zero  (occ_zero),
    .draining  (draining)
  );

  rdctl_start_gate #(.GUARD_CYC(GUARD_CYC)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .comp_or  (comp_or),
    .launch   (launch),
    .occ_zero (occ_zero),
    .draining (draining),
    .gate_ok  (gate_ok)
  );

  rdctl_strobe_fsm #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .comp_or   (comp_or),
    .gate_ok   (gate_ok),
    .out_free  (out_free),
    .shift_out (shift_out),
    .launch    (launch)
  );

  rdctl_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .lane_do   (lane_do),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_free  (out_free)
  );

  // R8: right after reset release nothing is presented and no strobe is high
  assert_reset_quiet_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> (!shift_out && !out_valid));

endmodule

// File: tb/fifo_rdctl_tb.sv
module fifo_rdctl_tb;

  localparam int LANES = 2;
  localparam int WIDTH = 4;
  localparam int DEPTH = 8;
  localparam int GUARD = 3;
  localparam int MHI   = 2;
  localparam int MLO   = 2;
  localparam int DW    = LANES * WIDTH;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          wr_pulse;
  logic [DW-1:0] wr_word;
  logic [LANES-1:0] lane_or, lane_ir, ovr_or_lo, ovr_ir_lo;
  logic [DW-1:0] lane_do;
  logic          shift_out, all_ir, comp_or, out_valid, out_ready;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  fifo_rdctl #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH), .GUARD_CYC(GUARD),
               .MIN_HI(MHI), .MIN_LO(MLO)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_pulse(wr_pulse),
    .lane_or(lane_or), .lane_ir(lane_ir), .lane_do(lane_do),
    .shift_out(shift_out), .all_ir(all_ir), .comp_or(comp_or),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  // behavioural lane FIFOs sharing one queue
  logic [DW-1:0] mq [0:DEPTH-1];
  int   m_cnt, m_rd, m_wr;
  logic m_or, so_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_rd <= 0; m_wr <= 0; m_or <= 1'b0; so_d <= 1'b0;
    end else begin
      automatic int c = m_cnt;
      if (so_d && !shift_out) begin
        m_rd <= (m_rd + 1) % DEPTH;
        c = c - 1;
      end
      if (wr_pulse) begin
        mq[m_wr] <= wr_word;
        m_wr <= (m_wr + 1) % DEPTH;
        c = c + 1;
      end
      m_cnt <= c;
      so_d  <= shift_out;
      m_or  <= (c > 0) && !shift_out;
    end
  end

  assign lane_or = {LANES{m_or}} & ~ovr_or_lo;
  assign lane_ir = {LANES{m_cnt < DEPTH}} & ~ovr_ir_lo;
  assign lane_do = mq[m_rd];

  // bookkeeping and monitor
  int checks = 0, fails = 0, cyc = 0;
  int pulses, or_rise_cyc, last_delay, hi_len, lo_len, min_hi, min_lo, mon_err;
  int rx_n, exp_n;
  logic [DW-1:0] rx [0:31];
  logic [DW-1:0] ex [0:31];
  logic prev_so, prev_cor;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    automatic logic cor = &lane_or;
    if (rst_n) begin
      if (cor && !prev_cor) or_rise_cyc = cyc;
      if (shift_out && !prev_so) begin
        if (!prev_cor) mon_err++;
        if (pulses > 0 && lo_len < min_lo) min_lo = lo_len;
        if (pulses > 0 && lo_len < MLO) mon_err++;
        last_delay = cyc - or_rise_cyc;
        pulses++;
        hi_len = 0;
      end
      if (!shift_out && prev_so) begin
        if (hi_len < min_hi) min_hi = hi_len;
        if (hi_len < MHI) mon_err++;
        lo_len = 0;
      end
      if (shift_out) hi_len++; else lo_len++;
      if (out_valid && out_ready && rx_n < 32) begin
        rx[rx_n] = out_data;
        rx_n++;
      end
    end
    prev_so  = shift_out;
    prev_cor = cor;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; wr_pulse = 1'b0; out_ready = 1'b1;
    ovr_or_lo = '0; ovr_ir_lo = '0;
    wait_cyc(2);
    pulses = 0; rx_n = 0; exp_n = 0; last_delay = -1; or_rise_cyc = 0;
    hi_len = 0; lo_len = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    wr_pulse = 1'b1; wr_word = w;
    ex[exp_n] = w; exp_n++;
    @(negedge clk);
    wr_pulse = 1'b0;
  endtask

  task automatic check_order(input string req);
    automatic bit ok = 1'b1;
    automatic int bad = 0;
    for (int i = 0; i < rx_n; i++)
      if (rx[i] !== ex[i]) begin ok = 1'b0; bad = i; end
    chk(ok, req, "word order/value", ok ? 0 : longint'(rx[bad]), ok ? 0 : longint'(ex[bad]));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(1);
    chk(shift_out == 1'b0, "R8", "shift_out in reset", shift_out, 0);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    do_reset(2'd0);
    chk(all_ir == 1'b1, "R1", "all_ir when empty", all_ir, 1);
  endtask

  task automatic t_handshake;
    do_reset(2'd0);
    push(8'hA5);
    wait_cyc(4);
    chk(last_delay == 1, "R9", "first strobe delay handshake", last_delay, 1);
    push(8'h3C);
    push(8'h7E);
    wait_cyc(40);
    chk(rx_n == 3, "R3", "words delivered", rx_n, 3);
    check_order("R3");
  endtask

  task automatic t_guard;
    do_reset(2'd1);
    push(8'h12);
    wait_cyc(20);
    chk(last_delay > GUARD, "R4", "guard delay first fill", last_delay, GUARD + 1);
    push(8'h34);
    wait_cyc(20);
    chk(last_delay > GUARD, "R4", "guard delay after re-arm", last_delay, GUARD + 1);
    chk(rx_n == 2, "R4", "guard words delivered", rx_n, 2);
    check_order("R4");
  endtask

  task automatic t_threshold;
    do_reset(2'd2);
    for (int i = 0; i < DEPTH / 2; i++) push(8'h40 + 8'(i));
    wait_cyc(30);
    chk(pulses == 0, "R5", "no strobe at half", pulses, 0);
    push(8'h4F);
    wait_cyc(80);
    chk(rx_n == DEPTH / 2 + 1, "R5", "drained after passing half", rx_n, DEPTH / 2 + 1);
    check_order("R5");
  endtask

  task automatic t_backpressure;
    do_reset(2'd0);
    out_ready = 1'b0;
    push(8'h91); push(8'h92); push(8'h93);
    wait_cyc(30);
    chk(pulses == 1, "R7", "strobes while stalled", pulses, 1);
    chk(out_valid == 1'b1, "R7", "word held", out_valid, 1);
    chk(out_data == 8'h91, "R7", "held word value", out_data, 8'h91);
    out_ready = 1'b1;
    wait_cyc(50);
    chk(rx_n == 3, "R7", "words after release", rx_n, 3);
    check_order("R7");
  endtask

  task automatic t_composite;
    do_reset(2'd0);
    ovr_or_lo = 2'b10;
    push(8'hC1);
    wait_cyc(20);
    chk(pulses == 0, "R1", "no strobe with one lane not ready", pulses, 0);
    ovr_ir_lo = 2'b01;
    @(negedge clk);
    chk(all_ir == 1'b0, "R1", "all_ir with one lane low", all_ir, 0);
    ovr_ir_lo = '0;
    @(negedge clk);
    chk(all_ir == 1'b1, "R1", "all_ir restored", all_ir, 1);
    for (int i = 1; i < DEPTH; i++) push(8'hC1 + 8'(i));
    @(negedge clk);
    chk(all_ir == 1'b0, "R1", "all_ir when full", all_ir, 0);
    ovr_or_lo = '0;
    wait_cyc(120);
    chk(rx_n == DEPTH, "R2", "full drain count", rx_n, DEPTH);
    check_order("R2");
  endtask

  task automatic t_reset_mid;
    do_reset(2'd2);
    out_ready = 1'b0;
    for (int i = 0; i < DEPTH / 2 + 1; i++) push(8'hE0 + 8'(i));
    wait_cyc(20);
    chk(pulses == 1, "R5", "one strobe before stall", pulses, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(shift_out == 1'b0 && out_valid == 1'b0, "R8", "outputs cleared by reset",
        {shift_out, out_valid}, 0);
    do_reset(2'd2);
    for (int i = 0; i < DEPTH / 2; i++) push(8'hF0 + 8'(i));
    wait_cyc(30);
    chk(pulses == 0, "R8", "occupancy cleared by reset", pulses, 0);
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0; wr_pulse = 1'b0; wr_word = '0; out_ready = 1'b1;
    ovr_or_lo = '0; ovr_ir_lo = '0;
    prev_so = 1'b0; prev_cor = 1'b0;
    min_hi = 1000; min_lo = 1000; mon_err = 0;
    pulses = 0; rx_n = 0; exp_n = 0; last_delay = -1; or_rise_cyc = 0;
    hi_len = 0; lo_len = 0;
    t_reset_state();
    t_handshake();
    t_guard();
    t_threshold();
    t_backpressure();
    t_composite();
    t_reset_mid();
    chk(mon_err == 0, "R6", "strobe width or rise violations", mon_err, 0);
    chk(min_hi >= MHI, "R6", "shortest high phase", min_hi, MHI);
    chk(min_lo >= MLO, "R6", "shortest low gap", min_lo, MLO);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule